// File: doc/BRIEF.md
# Operand-Size-Aware 64-bit Register File

This block holds sixteen 64-bit general-purpose registers. It has two combinational read ports and one synchronous write port. Each write carries an operand-size code, and the block merges the write into the destination by fixed rules. A doubleword (32-bit) write zero-fills the upper half of the destination. A byte or halfword write leaves every bit above its own field untouched. A quadword write replaces the whole register.

A mode input tells the block whether the core runs in full 64-bit mode or in a narrower mode where only the low 32 bits are architecturally defined. The block tracks the mode across clock edges. On the first edge after the core leaves 64-bit mode, it wipes the upper half of every register and marks each upper half as undefined. A flag on the write port handles a bit-scan whose source was zero: in 64-bit mode that write clears the destination's upper half and keeps its low half.

Reads that hit the register being written in the same cycle return the merged value that will be stored.

Top module: `sizereg_file`

## Requirements
- R1: A synchronous active-high reset sets every register to zero and marks every upper half as defined. A read in 64-bit mode then returns 0 with `rd_hi_def` high.
- R2: In 64-bit mode, a write with `wr_size` = 2'b11 (quadword) replaces all 64 bits of the destination and marks its upper half defined.
- R3: In 64-bit mode, a write with `wr_size` = 2'b10 (doubleword) stores `wr_data[31:0]` in bits [31:0], forces bits [63:32] to zero and marks the upper half defined.
- R4: A write with `wr_size` = 2'b01 (halfword) changes only bits [15:0]. Bits [63:16] and the upper-half defined flag keep their values, whatever the upper bits of `wr_data` are.
- R5: A write with `wr_size` = 2'b00 (byte) changes only bits [7:0]. Bits [63:8] and the upper-half defined flag keep their values.
- R6: On the first clock edge where `wide_mode` is low after being high, bits [63:32] of every register are cleared and marked undefined. After a return to 64-bit mode, those registers read zero in the upper half with `rd_hi_def` low until a doubleword, quadword or zero-source scan write defines them again.
- R7: While `wide_mode` is low, both read ports return zero in bits [63:32] and drive `rd_hi_def` low.
- R8: While `wide_mode` is low, a write with `wr_size` = 2'b11 is ignored and the destination keeps its contents.
- R9: In 64-bit mode, a write with `scan_zero` high ignores `wr_size` and `wr_data`. It clears bits [63:32] of the destination, keeps bits [31:0] and marks the upper half defined. Outside 64-bit mode such a write has no effect.
- R10: When a read port addresses the register that a write updates in the same cycle, it returns the merged value that will be stored. A port that reads another register is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = narrower mode |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Destination register |
| wr_size | input | 2 | Operand size: 00 byte, 01 halfword, 10 doubleword, 11 quadword |
| scan_zero | input | 1 | Write is a bit-scan result with a zero source |
| wr_data | input | 64 | Write data |
| rd_addr_a | input | 4 | Read port A address |
| rd_data_a | output | 64 | Read port A data |
| rd_hi_def_a | output | 1 | Read port A upper half defined |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | 64 | Read port B data |
| rd_hi_def_b | output | 1 | Read port B upper half defined |

## Verification
The assertions assume that `wide_mode` is a clean level, sampled only at the clock edge. They also assume that `wr_size` and `scan_zero` have no meaning unless `wr_en` is high. The stimulus changes every input only on the falling edge and keeps `scan_zero` and `wr_size` at rest whenever no write is in flight. It changes the mode only in cycles with no write, so that each register update comes from exactly one rule. The bench rebuilds the expected contents from masks of its own and compares them with both read ports.

// File: rtl/sizereg_pkg.sv
package sizereg_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_QUAD = 2'b11
  } opsize_e;

  // bits a write of the given size replaces
  function automatic word_t size_mask(opsize_e sz);
    case (sz)
      SZ_BYTE: return word_t'({8{1'b1}});
      SZ_HALF: return word_t'({16{1'b1}});
      SZ_WORD: return word_t'({HALF{1'b1}});
      default: return '1;
    endcase
  endfunction

  // merge rule: doubleword writes zero the top half, short writes keep it
  function automatic word_t merge_write(word_t old, word_t data, opsize_e sz);
    word_t m;
    word_t r;
    m = size_mask(sz);
    r = (old & ~m) | (data & m);
    if (sz == SZ_WORD) r[XLEN-1:HALF] = '0;
    return r;
  endfunction

  // value seen at a read port for the current mode
  function automatic word_t mode_view(word_t v, logic wide);
    return wide ? v : {{HALF{1'b0}}, v[HALF-1:0]};
  endfunction
endpackage

// File: rtl/rf_mode_track.sv
module rf_mode_track (
  input  logic clk,
  input  logic rst,
  input  logic wide_mode,
  output logic leave_pulse
);
  logic wide_q;

  always_ff @(posedge clk) begin
    if (rst) wide_q <= 1'b0;
    else     wide_q <= wide_mode;
  end

  assign leave_pulse = wide_q & ~wide_mode;

  AST_LEAVE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    leave_pulse |=> !leave_pulse); // R6
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import sizereg_pkg::*;
(
  input  logic    wide_mode,
  input  logic    wr_en,
  input  opsize_e wr_size,
  input  logic    scan_zero,
  input  word_t   wr_data,
  input  word_t   old_val,
  input  logic    old_hi_def,
  output logic    fire,
  output word_t   new_val,
  output logic    new_hi_def
);
  logic scan_fire;
  logic size_legal;

  assign scan_fire  = wr_en & scan_zero & wide_mode;
  assign size_legal = wide_mode | (wr_size != SZ_QUAD);
  assign fire       = scan_zero ? scan_fire : (wr_en & size_legal);

  always_comb begin
    if (scan_fire) begin
      new_val    = {{HALF{1'b0}}, old_val[HALF-1:0]};
      new_hi_def = 1'b1;
    end else begin
      new_val    = merge_write(old_val, wr_data, wr_size);
      new_hi_def = (wide_mode && (wr_size == SZ_WORD || wr_size == SZ_QUAD))
                   ? 1'b1 : old_hi_def;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import sizereg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide_mode,
  input  logic [AW-1:0] rd_addr,
  input  word_t         regs [NUM_REGS],
  input  logic [NUM_REGS-1:0] hi_def,
  input  logic          byp_fire,
  input  logic [AW-1:0] byp_addr,
  input  word_t         byp_val,
  input  logic          byp_hi_def,
  output word_t         rd_data,
  output logic          rd_hi_def
);
  logic  hit;
  word_t raw;
  logic  raw_def;

  assign hit = byp_fire && (byp_addr == rd_addr);

  always_comb begin
    raw     = hit ? byp_val    : regs[rd_addr];
    raw_def = hit ? byp_hi_def : hi_def[rd_addr];
  end

  assign rd_data   = mode_view(raw, wide_mode);
  assign rd_hi_def = wide_mode & raw_def;

  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> (rd_data[XLEN-1:HALF] == '0) && !rd_hi_def); // R7
endmodule

// File: rtl/sizereg_file.sv
module sizereg_file
  import sizereg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide_mode,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_size,
  input  logic            scan_zero,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  output logic            rd_hi_def_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  output logic            rd_hi_def_b
);
  word_t               regs   [NUM_REGS];
  logic [NUM_REGS-1:0] hi_def;
  logic                leave_pulse;
  logic                wr_fire;
  word_t               wr_new;
  logic                wr_new_def;
  opsize_e             size_e;

  assign size_e = opsize_e'(wr_size);

  rf_mode_track u_mode (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .leave_pulse(leave_pulse)
  );

  rf_write_merge u_merge (
    .wide_mode(wide_mode), .wr_en(wr_en), .wr_size(size_e),
    .scan_zero(scan_zero), .wr_data(wr_data),
    .old_val(regs[wr_addr]), .old_hi_def(hi_def[wr_addr]),
    .fire(wr_fire), .new_val(wr_new), .new_hi_def(wr_new_def)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic  sel;
    word_t nxt;
    logic  nxt_def;

    assign sel = wr_fire && (wr_addr == AW'(i));

    always_comb begin
      nxt     = regs[i];
      nxt_def = hi_def[i];
      if (sel) begin
        nxt     = wr_new;
        nxt_def = wr_new_def;
      end
      if (leave_pulse) begin
        nxt[XLEN-1:HALF] = '0;
        nxt_def          = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i]   <= '0;
        hi_def[i] <= 1'b1;
      end else begin
        regs[i]   <= nxt;
        hi_def[i] <= nxt_def;
      end
    end

    AST_QUAD_REPLACE: assert property (@(posedge clk) disable iff (rst)
      sel && wide_mode && !scan_zero && size_e == SZ_QUAD
      |=> regs[i] == $past(wr_data) && hi_def[i]); // R2
    AST_WORD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
      sel && wide_mode && !scan_zero && size_e == SZ_WORD
      |=> regs[i][XLEN-1:HALF] == '0 && hi_def[i]); // R3
    AST_HALF_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
      sel && !scan_zero && size_e == SZ_HALF && !leave_pulse
      |=> $stable(regs[i][XLEN-1:16]) && $stable(hi_def[i])); // R4
    AST_BYTE_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
      sel && !scan_zero && size_e == SZ_BYTE && !leave_pulse
      |=> $stable(regs[i][XLEN-1:8]) && $stable(hi_def[i])); // R5
    AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      leave_pulse |=> regs[i][XLEN-1:HALF] == '0 && !hi_def[i]); // R6
    AST_NARROW_QUAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
      wr_en && !wide_mode && !scan_zero && size_e == SZ_QUAD && !leave_pulse
      |=> $stable(regs[i]) && $stable(hi_def[i])); // R8
    AST_SCAN_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
      sel && scan_zero
      |=> $stable(regs[i][HALF-1:0]) && regs[i][XLEN-1:HALF] == '0); // R9
    AST_BYPASS_MATCH: assert property (@(posedge clk) disable iff (rst)
      sel && wide_mode && rd_addr_a == AW'(i)
      |=> regs[i] == $past(rd_data_a)); // R10
  end

  rf_read_port #(.NUM_REGS(NUM_REGS)) u_rd_a (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .rd_addr(rd_addr_a),
    .regs(regs), .hi_def(hi_def), .byp_fire(wr_fire), .byp_addr(wr_addr),
    .byp_val(wr_new), .byp_hi_def(wr_new_def),
    .rd_data(rd_data_a), .rd_hi_def(rd_hi_def_a)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS)) u_rd_b (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .rd_addr(rd_addr_b),
    .regs(regs), .hi_def(hi_def), .byp_fire(wr_fire), .byp_addr(wr_addr),
    .byp_val(wr_new), .byp_hi_def(wr_new_def),
    .rd_data(rd_data_b), .rd_hi_def(rd_hi_def_b)
  );
endmodule

// File: tb/tb_sizereg_file.sv
module tb_sizereg_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic        scan_zero = 1'b0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr_a = '0;
  logic [3:0]  rd_addr_b = '0;
  logic [63:0] rd_data_a, rd_data_b;
  logic        rd_hi_def_a, rd_hi_def_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] mem [16];
  logic        mdef [16];

  always #4 clk = ~clk;

  sizereg_file dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_size(wr_size), .scan_zero(scan_zero),
    .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_hi_def_a(rd_hi_def_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .rd_hi_def_b(rd_hi_def_b)
  );

  function automatic logic [63:0] expect_merge(logic [63:0] o, logic [63:0] d,
                                               logic [1:0] s);
    case (s)
      2'd0: return {o[63:8], d[7:0]};
      2'd1: return {o[63:16], d[15:0]};
      2'd2: return {32'h0, d[31:0]};
      default: return d;
    endcase
  endfunction

  task automatic model_write(int a, logic [1:0] s, logic [63:0] d, logic sc);
    if (sc) begin
      if (wide_mode) begin
        mem[a][63:32] = 32'h0;
        mdef[a] = 1'b1;
      end
    end else if (wide_mode) begin
      mem[a] = expect_merge(mem[a], d, s);
      if (s >= 2'd2) mdef[a] = 1'b1;
    end else if (s != 2'd3) begin
      mem[a] = expect_merge(mem[a], d, s);
    end
  endtask

  function automatic logic [63:0] seen(logic [63:0] v);
    return wide_mode ? v : {32'h0, v[31:0]};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic gd,
                       logic [63:0] exp, logic ed);
    checks++;
    if (got !== exp || gd !== ed) begin
      errors++;
      $display("FAIL %s: got %h def %b, expected %h def %b", tag, got, gd, exp, ed);
    end
  endtask

  task automatic read_check(string tag, int a);
    @(negedge clk);
    rd_addr_a = 4'(a);
    rd_addr_b = 4'(a);
    #1;
    check({tag, " port A"}, rd_data_a, rd_hi_def_a, seen(mem[a]), wide_mode & mdef[a]);
    check({tag, " port B"}, rd_data_b, rd_hi_def_b, seen(mem[a]), wide_mode & mdef[a]);
  endtask

  task automatic do_write(int a, logic [1:0] s, logic [63:0] d, logic sc);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_size = s; wr_data = d; scan_zero = sc;
    @(negedge clk);
    wr_en = 1'b0; scan_zero = 1'b0; wr_size = 2'd0;
    model_write(a, s, d, sc);
  endtask

  task automatic set_mode(logic w);
    @(negedge clk);
    if (wide_mode && !w) begin
      for (int i = 0; i < 16; i++) begin
        mem[i][63:32] = 32'h0;
        mdef[i] = 1'b0;
      end
    end
    wide_mode = w;
    @(negedge clk);
  endtask

  // R1: reset clears everything, even after writes
  task automatic t_reset;
    do_write(2, 2'd3, 64'h0123_4567_89AB_CDEF, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) begin mem[i] = '0; mdef[i] = 1'b1; end
    read_check("R1 reset r0", 0);
    read_check("R1 reset r2", 2);
    read_check("R1 reset r15", 15);
  endtask

  // R2: quadword write
  task automatic t_quad;
    do_write(3, 2'd3, 64'hDEAD_BEEF_CAFE_F00D, 1'b0);
    read_check("R2 quad r3", 3);
    do_write(15, 2'd3, 64'h8000_0000_0000_0001, 1'b0);
    read_check("R2 quad r15", 15);
  endtask

  // R3: doubleword write zero-fills
  task automatic t_word;
    do_write(4, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    do_write(4, 2'd2, 64'hAAAA_AAAA_1234_5678, 1'b0);
    read_check("R3 word r4", 4);
  endtask

  // R4, R5: short writes keep upper bits
  task automatic t_short;
    do_write(5, 2'd3, 64'h1111_2222_3333_4444, 1'b0);
    do_write(5, 2'd1, 64'h9999_8888_7777_ABCD, 1'b0);
    read_check("R4 half r5", 5);
    do_write(6, 2'd3, 64'h5555_6666_7777_8888, 1'b0);
    do_write(6, 2'd0, 64'hFFFF_FFFF_FFFF_FF3C, 1'b0);
    read_check("R5 byte r6", 6);
  endtask

  // R9: zero-source scan in wide mode
  task automatic t_scan;
    do_write(7, 2'd3, 64'h89AB_CDEF_0123_4567, 1'b0);
    do_write(7, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    read_check("R9 scan r7", 7);
  endtask

  // R10: same-cycle bypass on both ports, other register unaffected
  task automatic t_bypass;
    logic [63:0] exp;
    do_write(8, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    do_write(9, 2'd3, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd8; wr_size = 2'd1; wr_data = 64'h0000_0000_0000_1357;
    rd_addr_a = 4'd8; rd_addr_b = 4'd8;
    #1;
    exp = expect_merge(mem[8], wr_data, 2'd1);
    check("R10 bypass port A", rd_data_a, rd_hi_def_a, exp, 1'b1);
    check("R10 bypass port B", rd_data_b, rd_hi_def_b, exp, 1'b1);
    rd_addr_b = 4'd9;
    #1;
    check("R10 other reg port B", rd_data_b, rd_hi_def_b, mem[9], 1'b1);
    @(negedge clk);
    wr_en = 1'b0; wr_size = 2'd0;
    model_write(8, 2'd1, 64'h0000_0000_0000_1357, 1'b0);
    read_check("R10 after bypass r8", 8);
  endtask

  // R6, R7, R8, R9: leaving and returning to wide mode
  task automatic t_modes;
    do_write(10, 2'd3, 64'hFEDC_BA98_7654_3210, 1'b0);
    do_write(11, 2'd3, 64'h1357_9BDF_2468_ACE0, 1'b0);
    set_mode(1'b0);
    read_check("R7 narrow r10", 10);
    read_check("R7 narrow r11", 11);
    do_write(10, 2'd0, 64'h0000_0000_0000_00EE, 1'b0);
    read_check("R5 narrow byte r10", 10);
    do_write(11, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    read_check("R8 narrow quad ignored r11", 11);
    do_write(11, 2'd2, 64'h0, 1'b1);
    read_check("R9 narrow scan ignored r11", 11);
    set_mode(1'b1);
    read_check("R6 upper lost r10", 10);
    read_check("R6 upper lost r11", 11);
    read_check("R6 upper lost r3", 3);
    do_write(11, 2'd2, 64'h0000_0000_CAFE_BABE, 1'b0);
    read_check("R6 R3 redefined r11", 11);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; mdef[i] = 1'b1; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_quad();
    t_word();
    t_short();
    t_scan();
    t_bypass();
    t_modes();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule